// File: doc/BRIEF.md
# Flash March Self-Test Sequencer

This block runs a built-in march test over an embedded NOR flash array. A flash cell cannot be written to 1. Programming clears bits, and only a whole-array erase sets them back to 1. So each march element is built from erase, program and read operations instead of RAM-style writes. The sequencer drives address, data and one-cycle operation strobes through a test collar. After every erase or program it stalls until the array reports ready again. It compares every read against the value the algorithm expects.

The test runs six elements in a fixed order. First comes an erase. Then, in descending address order, each word is read as all ones, programmed to zero and read as zero. A descending pass then reads zero at every word. A second erase follows, then the same two march passes in ascending order. A run raises a sticky fail flag on any mismatch. It latches the first failing word and element into a report chain, which is shifted out serially once the run is over. When the test-select input is low, the collar joins the functional port straight to the array.

Top module: `flash_march_bist`

## Requirements
- R1: After reset, bist_done, bist_fail and ser_out are 0, and no erase, program or read strobe is driven while the block is idle.
- R2: While bist_sel is 0, arr_addr, arr_wdata, arr_erase, arr_prog and arr_read follow the fn_* inputs in the same cycle, and fn_rdata and fn_ready follow arr_rdata and arr_ready.
- R3: A run issues commands in this order. Element 0 is one erase. Element 1 goes from address 2^AW-1 down to 0, and each word gets read (expect ones), program, read (expect zeros). Element 2 reads zeros from 2^AW-1 down to 0. Element 3 is one erase. Element 4 repeats element 1 from address 0 up to 2^AW-1. Element 5 repeats element 2 in ascending order.
- R4: A run over N=2^AW words issues exactly 2 erases, 2N programs and 6N reads.
- R5: Erase and program strobes are one cycle wide, at most one strobe is active in any cycle, and program data is all zeros.
- R6: After an erase or program, no further command is issued until arr_ready is seen high. The wait has no time limit.
- R7: A read that differs from its expected word (all ones or all zeros) sets bist_fail. The run still completes. bist_fail stays set until the next accepted start.
- R8: The first mismatch of a run loads the report chain with a 1, the 3-bit element index (0 to 5 in the order of R3) and the AW-bit address. Later mismatches leave it unchanged. An accepted start clears the chain to zero.
- R9: When the block is not running, each cycle with shift_en high shifts the chain one place toward its MSB. ser_out presents the MSB, so the order is fail bit, element index MSB first, then address MSB first. ser_in enters at the LSB. shift_en has no effect during a run.
- R10: bist_done rises after the last read of element 5 and holds until the next accepted start. bist_start is accepted only when bist_sel is 1 and no run is in progress.
- R11: On a fault-free array, bist_fail stays 0 and the report chain shifts out as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_sel | input | 1 | 1: self-test owns the array; 0: functional pass-through |
| bist_start | input | 1 | Start pulse for a test run |
| shift_en | input | 1 | Shift the report chain by one place |
| ser_in | input | 1 | Serial data into the chain LSB |
| ser_out | output | 1 | Chain MSB |
| bist_done | output | 1 | Run finished |
| bist_fail | output | 1 | Sticky mismatch flag |
| fn_addr | input | AW | Functional address |
| fn_wdata | input | DW | Functional program data |
| fn_erase | input | 1 | Functional erase strobe |
| fn_prog | input | 1 | Functional program strobe |
| fn_read | input | 1 | Functional read strobe |
| fn_rdata | output | DW | Read data toward the functional side |
| fn_ready | output | 1 | Array ready toward the functional side |
| arr_addr | output | AW | Array address |
| arr_wdata | output | DW | Array program data |
| arr_erase | output | 1 | Array erase strobe |
| arr_prog | output | 1 | Array program strobe |
| arr_read | output | 1 | Array read strobe |
| arr_rdata | input | DW | Array read data, valid the cycle after a read strobe |
| arr_ready | input | 1 | Array idle |

## Verification
On every cycle, the assertions check the following:
- strobes are one-hot and single-cycle;
- no command is issued while the sequencer waits on a busy array;
- the fail and done flags stay sticky;
- the report chain stays frozen during a run once a failure has been captured.

Some behaviour only the bench scenarios can show. These are the exact command order and address direction of each element, and the operation totals. They also cover which fault lands in the report chain and the serial bit order. Three fault cases are injected:
- a stuck-at-1 bit;
- a stuck-at-0 bit;
- a program disturb on the next word, which only the ascending pass can expose.

The bench also checks pass-through and the rejection of starts while a run is active or the test select is low.

// File: rtl/flash_bist_pkg.sv
package flash_bist_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_READ  = 2'd3
  } flash_op_e;

  localparam int ELEM_W   = 3;
  localparam int NUM_ELEM = 6;

  typedef struct packed {
    logic       is_erase;
    logic       ascend;
    logic [1:0] nops;
  } elem_info_t;

  // Element table of the march: erase, down(r1,p0,r0), down(r0), erase, up(r1,p0,r0), up(r0)
  function automatic elem_info_t elem_info(logic [ELEM_W-1:0] e);
    elem_info_t i;
    i.is_erase = 1'b0;
    i.ascend   = 1'b0;
    i.nops     = 2'd1;
    case (e)
      3'd0, 3'd3: i.is_erase = 1'b1;
      3'd1:       i.nops = 2'd3;
      3'd2:       i.nops = 2'd1;
      3'd4:       begin i.ascend = 1'b1; i.nops = 2'd3; end
      default:    i.ascend = 1'b1;
    endcase
    return i;
  endfunction

  function automatic flash_op_e step_op(logic [ELEM_W-1:0] e, logic [1:0] k);
    elem_info_t i;
    i = elem_info(e);
    if (i.is_erase) return OP_ERASE;
    if (i.nops == 2'd3 && k == 2'd1) return OP_PROG;
    return OP_READ;
  endfunction

  // Expected read value: ones only for the first read of a three-step element
  function automatic logic expect_ones(logic [ELEM_W-1:0] e, logic [1:0] k);
    elem_info_t i;
    i = elem_info(e);
    return (i.nops == 2'd3) && (k == 2'd0);
  endfunction

endpackage

// File: rtl/flash_march_seq.sv
module flash_march_seq
  import flash_bist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              arr_ready,
  input  logic [DW-1:0]     arr_rdata,
  output logic              cmd_erase,
  output logic              cmd_prog,
  output logic              cmd_read,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_wdata,
  output logic              running,
  output logic              done,
  output logic              fail,
  output logic              cap_valid,
  output logic [ELEM_W-1:0] cap_elem,
  output logic [AW-1:0]     cap_addr
);

  localparam logic [AW-1:0]     ADDR_MAX  = {AW{1'b1}};
  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_SETTLE, S_WAIT, S_CHECK} seq_state_e;

  seq_state_e        state;
  logic [ELEM_W-1:0] elem, elem_n;
  logic [1:0]        opk, opk_n;
  logic [AW-1:0]     addr, addr_n;
  logic              finish_n;
  logic              done_q, fail_q;
  elem_info_t        ei, ei_next;
  flash_op_e         cur_op;
  logic              last_op, last_addr, mismatch;

  assign ei      = elem_info(elem);
  assign ei_next = elem_info(elem + ELEM_W'(1));
  assign cur_op  = step_op(elem, opk);

  // Next position in the march
  always_comb begin
    elem_n    = elem;
    opk_n     = opk;
    addr_n    = addr;
    finish_n  = 1'b0;
    last_op   = ei.is_erase || (opk == ei.nops - 2'd1);
    last_addr = ei.is_erase || (ei.ascend ? (addr == ADDR_MAX) : (addr == '0));
    if (!last_op) begin
      opk_n = opk + 2'd1;
    end else if (!last_addr) begin
      opk_n  = 2'd0;
      addr_n = ei.ascend ? addr + AW'(1) : addr - AW'(1);
    end else if (elem == LAST_ELEM) begin
      finish_n = 1'b1;
    end else begin
      elem_n = elem + ELEM_W'(1);
      opk_n  = 2'd0;
      addr_n = ei_next.ascend ? '0 : ADDR_MAX;
    end
  end

  assign mismatch = (arr_rdata != {DW{expect_ones(elem, opk)}});

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      elem   <= '0;
      opk    <= '0;
      addr   <= ADDR_MAX;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_ISSUE;
            elem   <= '0;
            opk    <= '0;
            addr   <= ADDR_MAX;
            done_q <= 1'b0;
            fail_q <= 1'b0;
          end
        end
        S_ISSUE:  state <= (cur_op == OP_READ) ? S_CHECK : S_SETTLE;
        S_SETTLE: state <= S_WAIT;
        S_WAIT: begin
          if (arr_ready) begin
            elem  <= elem_n;
            opk   <= opk_n;
            addr  <= addr_n;
            state <= finish_n ? S_IDLE : S_ISSUE;
            if (finish_n) done_q <= 1'b1;
          end
        end
        S_CHECK: begin
          if (mismatch) fail_q <= 1'b1;
          elem  <= elem_n;
          opk   <= opk_n;
          addr  <= addr_n;
          state <= finish_n ? S_IDLE : S_ISSUE;
          if (finish_n) done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_erase = (state == S_ISSUE) && (cur_op == OP_ERASE);
  assign cmd_prog  = (state == S_ISSUE) && (cur_op == OP_PROG);
  assign cmd_read  = (state == S_ISSUE) && (cur_op == OP_READ);
  assign cmd_addr  = addr;
  assign cmd_wdata = '0;
  assign running   = (state != S_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign cap_valid = (state == S_CHECK) && mismatch && !fail_q;
  assign cap_elem  = elem;
  assign cap_addr  = addr;

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_erase, cmd_prog, cmd_read}));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_erase || cmd_prog) |=> !(cmd_erase || cmd_prog));

  p_stall_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !arr_ready) |=> !(cmd_erase || cmd_prog || cmd_read));

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !start) |=> fail_q);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q);

endmodule

// File: rtl/flash_bist_report.sv
module flash_bist_report
  import flash_bist_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              running,
  input  logic              cap_valid,
  input  logic [ELEM_W-1:0] cap_elem,
  input  logic [AW-1:0]     cap_addr,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic              ser_out
);

  localparam int RW = 1 + ELEM_W + AW;

  logic [RW-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      chain <= '0;
    end else if (cap_valid) begin
      chain <= {1'b1, cap_elem, cap_addr};
    end else if (shift_en && !running) begin
      chain <= {chain[RW-2:0], ser_in};
    end
  end

  assign ser_out = chain[RW-1];

  p_keep_first_r8: assert property (@(posedge clk) disable iff (rst)
    (running && chain[RW-1] && !clear) |=> $stable(chain));

endmodule

// File: rtl/flash_test_collar.sv
module flash_test_collar #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          bist_sel,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_erase,
  input  logic          b_prog,
  input  logic          b_read,
  input  logic [AW-1:0] fn_addr,
  input  logic [DW-1:0] fn_wdata,
  input  logic          fn_erase,
  input  logic          fn_prog,
  input  logic          fn_read,
  output logic [DW-1:0] fn_rdata,
  output logic          fn_ready,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          arr_erase,
  output logic          arr_prog,
  output logic          arr_read,
  input  logic [DW-1:0] arr_rdata,
  input  logic          arr_ready
);

  always_comb begin
    if (bist_sel) begin
      arr_addr  = b_addr;
      arr_wdata = b_wdata;
      arr_erase = b_erase;
      arr_prog  = b_prog;
      arr_read  = b_read;
    end else begin
      arr_addr  = fn_addr;
      arr_wdata = fn_wdata;
      arr_erase = fn_erase;
      arr_prog  = fn_prog;
      arr_read  = fn_read;
    end
  end

  assign fn_rdata = arr_rdata;
  assign fn_ready = arr_ready;

endmodule

// File: rtl/flash_march_bist.sv
module flash_march_bist
  import flash_bist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bist_sel,
  input  logic          bist_start,
  input  logic          shift_en,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          bist_done,
  output logic          bist_fail,
  input  logic [AW-1:0] fn_addr,
  input  logic [DW-1:0] fn_wdata,
  input  logic          fn_erase,
  input  logic          fn_prog,
  input  logic          fn_read,
  output logic [DW-1:0] fn_rdata,
  output logic          fn_ready,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          arr_erase,
  output logic          arr_prog,
  output logic          arr_read,
  input  logic [DW-1:0] arr_rdata,
  input  logic          arr_ready
);

  logic              start_ok, running;
  logic              s_erase, s_prog, s_read;
  logic [AW-1:0]     s_addr;
  logic [DW-1:0]     s_wdata;
  logic              cap_valid;
  logic [ELEM_W-1:0] cap_elem;
  logic [AW-1:0]     cap_addr;

  assign start_ok = bist_start && bist_sel && !running;

  flash_march_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .start(start_ok),
    .arr_ready(arr_ready), .arr_rdata(arr_rdata),
    .cmd_erase(s_erase), .cmd_prog(s_prog), .cmd_read(s_read),
    .cmd_addr(s_addr), .cmd_wdata(s_wdata),
    .running(running), .done(bist_done), .fail(bist_fail),
    .cap_valid(cap_valid), .cap_elem(cap_elem), .cap_addr(cap_addr)
  );

  flash_bist_report #(.AW(AW)) u_report (
    .clk(clk), .rst(rst), .clear(start_ok), .running(running),
    .cap_valid(cap_valid), .cap_elem(cap_elem), .cap_addr(cap_addr),
    .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out)
  );

  flash_test_collar #(.AW(AW), .DW(DW)) u_collar (
    .bist_sel(bist_sel),
    .b_addr(s_addr), .b_wdata(s_wdata), .b_erase(s_erase), .b_prog(s_prog), .b_read(s_read),
    .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_erase(fn_erase), .fn_prog(fn_prog),
    .fn_read(fn_read), .fn_rdata(fn_rdata), .fn_ready(fn_ready),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_erase(arr_erase),
    .arr_prog(arr_prog), .arr_read(arr_read), .arr_rdata(arr_rdata), .arr_ready(arr_ready)
  );

endmodule

// File: tb/test_flash_march_bist.sv
module test_flash_march_bist;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int RW = 1 + 3 + AW;
  localparam int ERASE_LAT = 20;
  localparam int PROG_LAT  = 3;

  localparam logic [1:0] T_ERASE = 2'd1, T_PROG = 2'd2, T_READ = 2'd3;

  typedef struct packed { logic [1:0] op; logic [AW-1:0] a; } cmd_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bist_sel = 1'b1, bist_start = 1'b0, shift_en = 1'b0, ser_in = 1'b0;
  logic ser_out, bist_done, bist_fail;
  logic [AW-1:0] fn_addr = '0;
  logic [DW-1:0] fn_wdata = '0;
  logic fn_erase = 1'b0, fn_prog = 1'b0, fn_read = 1'b0;
  logic [DW-1:0] fn_rdata;
  logic fn_ready;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic arr_erase, arr_prog, arr_read;
  logic [DW-1:0] arr_rdata;
  logic arr_ready;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_march_bist #(.AW(AW), .DW(DW)) i_flash_march_bist (
    .clk(clk), .rst(rst), .bist_sel(bist_sel), .bist_start(bist_start),
    .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out),
    .bist_done(bist_done), .bist_fail(bist_fail),
    .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_erase(fn_erase), .fn_prog(fn_prog),
    .fn_read(fn_read), .fn_rdata(fn_rdata), .fn_ready(fn_ready),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_erase(arr_erase),
    .arr_prog(arr_prog), .arr_read(arr_read), .arr_rdata(arr_rdata), .arr_ready(arr_ready)
  );

  // ---------------- behavioural flash array with fault injection ----------------
  logic [DW-1:0] mem [N];
  logic [DW-1:0] sa0 [N];
  logic [DW-1:0] sa1 [N];
  logic          dist_on = 1'b0;
  int            dist_a  = 0;
  int            busy;

  assign arr_ready = (busy == 0);

  always @(posedge clk) begin
    if (rst) begin
      busy <= 0;
      arr_rdata <= '0;
      for (int i = 0; i < N; i++) mem[i] <= '1;
    end else begin
      if (busy != 0) busy <= busy - 1;
      if (arr_erase) begin
        for (int i = 0; i < N; i++) mem[i] <= '1;
        busy <= ERASE_LAT;
      end else if (arr_prog) begin
        mem[arr_addr] <= mem[arr_addr] & arr_wdata;
        if (dist_on && int'(arr_addr) == dist_a && dist_a < N-1) mem[dist_a+1] <= '0;
        busy <= PROG_LAT;
      end
      if (arr_read) arr_rdata <= (mem[arr_addr] | sa1[arr_addr]) & ~sa0[arr_addr];
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  cmd_t sb[$];
  int   n_erase, n_prog, n_read, busy_issue, pulse_bad, wdata_bad;
  logic prev_pe = 1'b0;

  task automatic push_run();
    sb.delete();
    for (int e = 0; e < 6; e++) begin
      if (e == 0 || e == 3) begin
        sb.push_back('{op: T_ERASE, a: '0});
      end else begin
        for (int s = 0; s < N; s++) begin
          logic [AW-1:0] a;
          a = (e < 3) ? AW'(N-1-s) : AW'(s);
          if (e == 1 || e == 4) begin
            sb.push_back('{op: T_READ, a: a});
            sb.push_back('{op: T_PROG, a: a});
          end
          sb.push_back('{op: T_READ, a: a});
        end
      end
    end
    n_erase = 0; n_prog = 0; n_read = 0; busy_issue = 0; pulse_bad = 0; wdata_bad = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && bist_sel) begin
      logic [1:0] op;
      op = arr_erase ? T_ERASE : arr_prog ? T_PROG : arr_read ? T_READ : 2'd0;
      if ((arr_erase + arr_prog + arr_read) > 1) pulse_bad++;
      if (prev_pe && (arr_erase || arr_prog)) pulse_bad++;
      prev_pe = arr_erase || arr_prog;
      if (op != 2'd0) begin
        if (!arr_ready) busy_issue++;
        if (op == T_ERASE) n_erase++;
        if (op == T_PROG) begin
          n_prog++;
          if (arr_wdata != '0) wdata_bad++;
        end
        if (op == T_READ) n_read++;
        if (sb.size() == 0) begin
          check("R3", "unexpected command (queue empty)", {30'd0, op}, 32'd0);
        end else begin
          cmd_t x;
          x = sb.pop_front();
          check("R3", "command op", {30'd0, op}, {30'd0, x.op});
          if (x.op != T_ERASE) check("R3", "command address", {28'd0, arr_addr}, {28'd0, x.a});
        end
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic pulse_start();
    @(negedge clk); bist_start = 1'b1;
    @(negedge clk); bist_start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!bist_done && n < 5000);
    check("R10", "bist_done reached", {31'd0, bist_done}, 32'd1);
  endtask

  task automatic shift_report(input logic sin, output logic [RW-1:0] v);
    v = '0;
    ser_in = sin;
    for (int i = 0; i < RW; i++) begin
      @(negedge clk);
      v = {v[RW-2:0], ser_out};
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic run_checks(string tag);
    check("R3", {tag, " queue drained"}, sb.size(), 0);
    check("R4", {tag, " erase count"}, n_erase, 2);
    check("R4", {tag, " program count"}, n_prog, 2*N);
    check("R4", {tag, " read count"}, n_read, 6*N);
    check("R5", {tag, " strobe shape"}, pulse_bad, 0);
    check("R5", {tag, " program data zero"}, wdata_bad, 0);
    check("R6", {tag, " commands while busy"}, busy_issue, 0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [RW-1:0] rep;
    for (int i = 0; i < N; i++) begin sa0[i] = '0; sa1[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", "done after reset", {31'd0, bist_done}, 0);
    check("R1", "fail after reset", {31'd0, bist_fail}, 0);
    check("R1", "ser_out after reset", {31'd0, ser_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "idle strobes", {29'd0, arr_erase, arr_prog, arr_read}, 0);

    // Pass-through and ignored start while bist_sel is low
    bist_sel = 1'b0;
    fn_addr = 4'd2; fn_wdata = 8'hA5; fn_prog = 1'b1;
    #1;
    check("R2", "addr pass", {28'd0, arr_addr}, 2);
    check("R2", "wdata pass", {24'd0, arr_wdata}, 32'hA5);
    check("R2", "prog pass", {29'd0, arr_erase, arr_prog, arr_read}, 3'b010);
    @(negedge clk); fn_prog = 1'b0;
    #1;
    check("R2", "ready pass (busy)", {31'd0, fn_ready}, {31'd0, arr_ready});
    check("R2", "ready low after program", {31'd0, fn_ready}, 0);
    repeat (PROG_LAT + 1) @(negedge clk);
    fn_read = 1'b1;
    @(negedge clk); fn_read = 1'b0;
    check("R2", "rdata pass", {24'd0, fn_rdata}, 32'hA5);
    pulse_start();
    repeat (3) @(negedge clk);
    bist_sel = 1'b1;
    #1;
    check("R10", "start ignored when deselected (strobes)", {29'd0, arr_erase, arr_prog, arr_read}, 0);
    repeat (3) @(negedge clk);
    check("R10", "start ignored when deselected (done)", {31'd0, bist_done}, 0);
    check("R10", "start ignored (no command seen)", sb.size(), 0);

    // Run 1: fault-free, second start mid-run must be ignored
    push_run();
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_done();
    run_checks("clean");
    check("R11", "clean run fail flag", {31'd0, bist_fail}, 0);
    repeat (4) @(negedge clk);
    check("R10", "done holds", {31'd0, bist_done}, 1);
    shift_report(1'b1, rep);
    check("R11", "clean report chain", {24'd0, rep}, 0);
    check("R9", "ser_in reached MSB", {31'd0, ser_out}, 1);

    // Run 2: stuck-at-1 at word 9, stuck-at-0 at word 3
    sa1[9] = 8'h10;
    sa0[3] = 8'h02;
    push_run();
    pulse_start();
    check("R7", "fail cleared by start", {31'd0, bist_fail}, 0);
    check("R10", "done cleared by start", {31'd0, bist_done}, 0);
    wait_done();
    run_checks("stuck");
    check("R7", "fail set and sticky", {31'd0, bist_fail}, 1);
    shift_report(1'b0, rep);
    check("R8", "first failure {1,elem1,addr9}", {24'd0, rep}, {24'd0, 1'b1, 3'd1, 4'd9});
    check("R9", "chain filled from ser_in", {31'd0, ser_out}, 0);
    sa1[9] = '0;
    sa0[3] = '0;

    // Run 3: program of word 5 disturbs word 6; shifting held high during the run
    dist_on = 1'b1; dist_a = 5;
    push_run();
    pulse_start();
    shift_en = 1'b1; ser_in = 1'b1;
    wait_done();
    shift_en = 1'b0;
    run_checks("disturb");
    check("R7", "disturb detected", {31'd0, bist_fail}, 1);
    shift_report(1'b0, rep);
    check("R9", "shift ignored during run; R8 ascending capture {1,elem4,addr6}",
          {24'd0, rep}, {24'd0, 1'b1, 3'd4, 4'd6});
    dist_on = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule